// File: doc/BRIEF.md
# Power-State Clock Gating Window Controller

This block decides whether the internal clocks of a link-attached device may be stopped while the link stop signal is asserted. It does not gate clocks on every stop assertion. Gating is allowed only inside a window. A stop-grant broadcast opens the window when its system management action code is enabled in a programmable mask. A separate stop-clock-deassertion broadcast closes the window. A stop assertion that no matching grant came before therefore leaves the clocks running.

Upstream logic decodes the link messages and delivers them as single-cycle strobes, together with the action code field. A configuration register supplies the enable mask. The block has two outputs. One is a clock enable for an external gating cell. The other is a hold signal that stops the host side from issuing upstream requests while clocks are stopped and while they restart. The stop input is asynchronous and passes through a two-flop synchronizer. The reset is asynchronous and is released synchronously inside the block.

Top module: `clk_gate_window`

## Requirements
- R1: After reset the window is closed, `clk_en` is 1 and `req_hold` is 0.
- R2: A `grant_stb` pulse whose code is enabled in `gate_mask` opens the window. A later rising edge of `link_stop` then drives `clk_en` to 0 on the third clock edge after the change: two synchronizer stages plus one gating register.
- R3: A `grant_stb` pulse whose code bit in `gate_mask` is 0 leaves the window unchanged. An open window stays open and a closed window stays closed.
- R4: While the window is closed, asserting `link_stop` keeps `clk_en` at 1 and `req_hold` at 0.
- R5: A `release_stb` pulse closes the window, so later `link_stop` assertions do not gate clocks.
- R6: After `link_stop` falls, `clk_en` returns to 1 on the third clock edge. `req_hold` clears one edge later.
- R7: `req_hold` is 1 in every cycle in which `clk_en` is 0.
- R8: The window stays open across repeated `link_stop` assertions until a `release_stb` is seen.
- R9: When `release_stb` and an enabled `grant_stb` arrive in the same cycle, the release wins and the window ends closed.
- R10: Gating starts only on a rising edge of the synchronized stop. If the window opens while `link_stop` is already high, clocks keep running until stop falls and rises again.
- R11: The mask is indexed by code value: bit k of `gate_mask` enables action code k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_stop | input | 1 | Asynchronous link stop signal, active high |
| grant_stb | input | 1 | One-cycle strobe: stop-grant broadcast decoded |
| grant_code | input | CODE_W | Action code carried by the stop-grant |
| release_stb | input | 1 | One-cycle strobe: stop-clock-deassertion broadcast decoded |
| gate_mask | input | 2**CODE_W | Enable bit per action code |
| clk_en | output | 1 | Clock enable for the external gating cell, 1 = running |
| req_hold | output | 1 | Holds off upstream request issue |

## Verification
Two window events can land in the same cycle: an enabled stop-grant that opens the window and a deassertion message that closes it. The bench drives both strobes on one clock edge, with the window first closed and then open. It then asserts the stop line and expects the clocks to keep running. A second overlap is between opening the window and the stop line already being high. That case is provoked by arming mid-assertion, and it is judged by clocks that stay running until a fresh rising edge.

// File: rtl/cgw_pkg.sv
package cgw_pkg;
  typedef enum logic {
    WIN_SHUT = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;

  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/cgw_sync.sv
module cgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nxt = d_async;
    end else begin : g_many
      always_comb chain_nxt = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cgw_rst_sync.sv
module cgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] rel_q;
  logic [STAGES-1:0] rel_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb rel_nxt = 1'b1;
    end else begin : g_many
      always_comb rel_nxt = {rel_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) rel_q <= '0;
    else              rel_q <= rel_nxt;
  end

  assign rst_n_sync = rel_q[STAGES-1];
endmodule

// File: rtl/cgw_window.sv
module cgw_window
  import cgw_pkg::*;
#(
  parameter int CODE_W = 3,
  localparam int MASK_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_stb,
  input  logic [CODE_W-1:0] grant_code,
  input  logic              release_stb,
  input  logic [MASK_W-1:0] gate_mask,
  output logic              armed
);
  win_state_t win_q;
  win_state_t win_nxt;
  logic       code_hit;
  logic       win_en;

  always_comb begin
    code_hit = gate_mask[grant_code];
    win_en   = release_stb | (grant_stb & code_hit);
    win_nxt  = win_q;
    if (release_stb)                win_nxt = WIN_SHUT;
    else if (grant_stb && code_hit) win_nxt = WIN_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= WIN_SHUT;
    else if (win_en) win_q <= win_nxt;
  end

  assign armed = (win_q == WIN_OPEN);

  // R5
  release_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_stb |=> !armed);

  // R3
  unmasked_grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_stb && !gate_mask[grant_code] && !release_stb) |=> $stable(armed));

  // R2
  masked_grant_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_stb && gate_mask[grant_code] && !release_stb) |=> armed);
endmodule

// File: rtl/cgw_gate_ctrl.sv
module cgw_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_sync,
  input  logic armed,
  output logic clk_en,
  output logic req_hold
);
  logic stop_q;
  logic gated_q;
  logic tail_q;
  logic stop_rise;
  logic gated_nxt;

  always_comb begin
    stop_rise = stop_sync & ~stop_q;
    if (gated_q) gated_nxt = stop_sync;
    else         gated_nxt = stop_rise & armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      gated_q <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      stop_q  <= stop_sync;
      gated_q <= gated_nxt;
      tail_q  <= gated_q;
    end
  end

  assign clk_en   = ~gated_q;
  assign req_hold = gated_q | tail_q;

  // R7
  hold_while_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> req_hold);

  // R6
  hold_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (req_hold ##1 !req_hold));

  // R4
  closed_no_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !armed) |=> clk_en);

  // R10
  edge_only_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !stop_rise) |=> clk_en);
endmodule

// File: rtl/clk_gate_window.sv
module clk_gate_window
  import cgw_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int MASK_W     = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_stop,
  input  logic              grant_stb,
  input  logic [CODE_W-1:0] grant_code,
  input  logic              release_stb,
  input  logic [MASK_W-1:0] gate_mask,
  output logic              clk_en,
  output logic              req_hold
);
  logic rst_n_int;
  logic stop_sync;
  logic armed;

  cgw_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  cgw_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (link_stop),
    .q_sync  (stop_sync)
  );

  cgw_window #(.CODE_W(CODE_W)) u_window (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .grant_stb   (grant_stb),
    .grant_code  (grant_code),
    .release_stb (release_stb),
    .gate_mask   (gate_mask),
    .armed       (armed)
  );

  cgw_gate_ctrl u_gate (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .stop_sync (stop_sync),
    .armed     (armed),
    .clk_en    (clk_en),
    .req_hold  (req_hold)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n_int |-> (clk_en && !req_hold));
endmodule

// File: tb/clk_gate_window_tb.sv
module clk_gate_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 3;
  localparam int MASK_W     = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              link_stop;
  logic              grant_stb;
  logic [CODE_W-1:0] grant_code;
  logic              release_stb;
  logic [MASK_W-1:0] gate_mask;
  logic              clk_en;
  logic              req_hold;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_gate_window #(.CODE_W(CODE_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_stop   (link_stop),
    .grant_stb   (grant_stb),
    .grant_code  (grant_code),
    .release_stb (release_stb),
    .gate_mask   (gate_mask),
    .clk_en      (clk_en),
    .req_hold    (req_hold)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic exp_en, input logic exp_hold);
    chk(clk_en == exp_en, {tag, " clk_en"}, int'(clk_en), int'(exp_en));
    chk(req_hold == exp_hold, {tag, " req_hold"}, int'(req_hold), int'(exp_hold));
  endtask

  task automatic send_grant(input logic [CODE_W-1:0] code, input logic with_release);
    grant_stb   = 1'b1;
    grant_code  = code;
    release_stb = with_release;
    tick();
    grant_stb   = 1'b0;
    release_stb = 1'b0;
  endtask

  task automatic send_release();
    release_stb = 1'b1;
    tick();
    release_stb = 1'b0;
  endtask

  // Full stop assertion with timing checks; expect_gate selects gated or running.
  task automatic stop_cycle(input bit expect_gate, input string tag);
    link_stop = 1'b1;
    tick(2);
    chk_out({tag, " pre-sync"}, 1'b1, 1'b0);
    tick();
    chk_out({tag, " stop edge3"}, !expect_gate, expect_gate);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_out({tag, " stop held"}, !expect_gate, expect_gate);
    end
    link_stop = 1'b0;
    tick(2);
    chk_out({tag, " fall edge2"}, !expect_gate, expect_gate);
    tick();
    chk_out({tag, " R6 fall edge3"}, 1'b1, expect_gate);
    tick();
    chk_out({tag, " R6 fall edge4"}, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 1'b1, 1'b0);
    stop_cycle(1'b0, "R1 closed after reset");
  endtask

  task automatic t_unarmed();
    stop_cycle(1'b0, "R4 unarmed stop");
  endtask

  task automatic t_arm_gate();
    send_grant(3'd5, 1'b0);
    stop_cycle(1'b1, "R2 R7 R11 code5 gate");
  endtask

  task automatic t_repeat();
    stop_cycle(1'b1, "R8 repeat gate");
  endtask

  task automatic t_release();
    send_release();
    stop_cycle(1'b0, "R5 after release");
  endtask

  task automatic t_unmasked();
    send_grant(3'd3, 1'b0);
    stop_cycle(1'b0, "R3 R11 code3 closed stays");
    send_grant(3'd2, 1'b0);
    send_grant(3'd3, 1'b0);
    stop_cycle(1'b1, "R3 code3 open stays");
    send_release();
  endtask

  task automatic t_collide();
    send_grant(3'd5, 1'b1);
    stop_cycle(1'b0, "R9 collide from closed");
    send_grant(3'd2, 1'b0);
    send_grant(3'd2, 1'b1);
    stop_cycle(1'b0, "R9 collide from open");
  endtask

  task automatic t_late_arm();
    link_stop = 1'b1;
    tick(5);
    send_grant(3'd2, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_out("R10 armed mid-stop", 1'b1, 1'b0);
    end
    link_stop = 1'b0;
    tick(4);
    stop_cycle(1'b1, "R10 fresh edge");
    send_release();
  endtask

  initial begin
    rst_n       = 1'b0;
    link_stop   = 1'b0;
    grant_stb   = 1'b0;
    grant_code  = '0;
    release_stb = 1'b0;
    gate_mask   = 8'b0010_0100;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_unarmed();
    t_arm_gate();
    t_repeat();
    t_release();
    t_unmasked();
    t_collide();
    t_late_arm();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule